// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock generator and the board-level clock pins and gates groups of clocks for power management. Six source clocks come in on their own inputs (processor, PCI, AGP, memory, USB and reference). They fan out to four processor outputs, four gated PCI outputs and one free-running PCI output, two AGP outputs, twelve memory clock outputs, one USB output and one reference output. Three active-high requests (processor stop, PCI stop, power down) share their pins with three of the memory clock outputs. A strap input decides which role those pins have.

Each request is resynchronised into the domain of the clocks it affects. A two-flop chain, clocked on the falling edge of the source clock, produces the gate enable. The enable therefore only changes while the source is low, so every output starts with a full high phase and parks low after a full high phase. Power down is sequenced by a four-state machine in the reference domain:
- `PS_LOCK`: waits a set number of cycles for lock.
- `PS_RUN`: outputs enabled.
- `PS_DRAIN`: enables withdrawn while the oscillator is kept on.
- `PS_DOWN`: oscillator/PLL enable dropped.

The transitions are:
- LOCK→RUN after `LOCK_CYCLES` cycles.
- LOCK→DRAIN or RUN→DRAIN when the power-down request is seen.
- DRAIN→DOWN after `DRAIN_CYCLES` cycles.
- DOWN→LOCK when the request is released.

Top module: `clkstop_ctrl`

## Requirements
- R1: While the processor-stop request is active and the machine is in PS_RUN, all four processor clock outputs rest low, and the other groups keep toggling.
- R2: While the PCI-stop request is active, the four gated PCI outputs rest low, and the free-running PCI output keeps toggling.
- R3: While the power-down request is active, every clock output rests low. The oscillator enable output goes low only after `DRAIN_CYCLES` reference cycles in PS_DRAIN, by which time every output is already low.
- R4: With the strap low, the shared pins are read as requests: memory bit 5 is power down, bit 6 is processor stop and bit 7 is PCI stop. Those three memory outputs are held low and `shared_pin_oe` is 0. With the strap high, all three requests are treated as inactive, those bits carry the memory clock and `shared_pin_oe` is 1.
- R5: No output high or low phase is ever shorter than half the period of its source clock, including while requests toggle at random times.
- R6: After power down is released, no output rises for at least `LOCK_CYCLES` reference cycles. Exactly `LOCK_CYCLES` cycles are spent in PS_LOCK, after which the outputs resume.
- R7: Power down overrides both stops. Releasing a processor or PCI stop while powered down restarts nothing.
- R8: While reset is asserted, every clock output is low and the oscillator enable is high (machine in PS_LOCK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Reference source clock; also clocks the power state machine |
| cpu_clk_in | input | 1 | Processor source clock |
| pci_clk_in | input | 1 | PCI source clock |
| agp_clk_in | input | 1 | AGP source clock |
| sdram_clk_in | input | 1 | Memory source clock |
| usb_clk_in | input | 1 | USB source clock |
| strap_mode | input | 1 | 0: shared pins are requests; 1: shared pins are memory clocks |
| pin_pdn_in | input | 1 | Shared pin, power-down request (active high) |
| pin_cpu_stop_in | input | 1 | Shared pin, processor-stop request (active high) |
| pin_pci_stop_in | input | 1 | Shared pin, PCI-stop request (active high) |
| cpu_clk_o | output | N_CPU (4) | Gated processor clocks |
| pci_clk_o | output | N_PCI_GATED (4) | Gated PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock (stopped only by power down) |
| agp_clk_o | output | N_AGP (2) | AGP clocks |
| sdram_clk_o | output | N_SDRAM (12) | Memory clocks; bits 5..7 are the shared pins |
| shared_pin_oe | output | 1 | Output drive enable for the three shared pins |
| usb_clk_o | output | 1 | USB clock |
| ref_clk_o | output | 1 | Reference clock output |
| osc_en_o | output | 1 | Oscillator/PLL enable |

## Verification
The case that matters is a group stop and power down acting in the same cycle. The processor enable may be falling because of its own stop request just as the drain state withdraws the run enable. A stop may also be released in the same reference cycle that the machine moves from PS_LOCK to PS_RUN. The bench provokes both. The vector table asserts and drops the processor and PCI stops together with power down and releases one while still powered down. A random phase then toggles all three requests at arbitrary sub-cycle offsets. The outcome is judged at the pins: output activity per group after settling, the level of the oscillator enable, and a width monitor on every output that flags any phase shorter than half its source period.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        PS_LOCK  = 2'd0,
        PS_RUN   = 2'd1,
        PS_DRAIN = 2'd2,
        PS_DOWN  = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int WIDTH = 1
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             allow,
    output logic             en_o,
    output logic [WIDTH-1:0] clk_o
);

    logic meta_q;
    logic en_q;

    // Both stages run on the falling edge, so the enable moves only while
    // the source clock is low and the AND below cannot cut a phase.
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            meta_q <= allow;
            en_q   <= meta_q;
        end
    end

    assign en_o  = en_q;
    assign clk_o = {WIDTH{clk_in & en_q}};

endmodule

// File: rtl/clkstop_pwr_fsm.sv
module clkstop_pwr_fsm
    import clkstop_pkg::*;
#(
    parameter int LOCK_CYCLES  = 16,
    parameter int DRAIN_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_req,
    output pwr_state_e state_o,
    output logic       run_o,
    output logic       osc_en_o
);

    localparam int MAXC = (LOCK_CYCLES > DRAIN_CYCLES) ? LOCK_CYCLES : DRAIN_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CYCLES - 1);
    localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_CYCLES - 1);

    pwr_state_e    state_q;
    pwr_state_e    state_d;
    logic [CW-1:0] cnt_q;
    logic          pdn_meta_q;
    logic          pdn_sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdn_meta_q <= 1'b0;
            pdn_sync_q <= 1'b0;
        end else begin
            pdn_meta_q <= pdn_req;
            pdn_sync_q <= pdn_meta_q;
        end
    end

    // State register and its dwell counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_LOCK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == PS_LOCK || state_q == PS_DRAIN)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_LOCK: begin
                if (pdn_sync_q)
                    state_d = PS_DRAIN;
                else if (cnt_q == LOCK_LAST)
                    state_d = PS_RUN;
            end
            PS_RUN: begin
                if (pdn_sync_q)
                    state_d = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (cnt_q == DRAIN_LAST)
                    state_d = PS_DOWN;
            end
            PS_DOWN: begin
                if (!pdn_sync_q)
                    state_d = PS_LOCK;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        state_o  = state_q;
        run_o    = (state_q == PS_RUN);
        osc_en_o = (state_q != PS_DOWN);
    end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU        = 4,
    parameter int N_PCI_GATED  = 4,
    parameter int N_AGP        = 2,
    parameter int N_SDRAM      = 12,
    parameter int SH_PDN_BIT   = 5,
    parameter int SH_CPU_BIT   = 6,
    parameter int SH_PCI_BIT   = 7,
    parameter int LOCK_CYCLES  = 16,
    parameter int DRAIN_CYCLES = 8
) (
    input  logic                   rst_n,
    input  logic                   ref_clk_in,
    input  logic                   cpu_clk_in,
    input  logic                   pci_clk_in,
    input  logic                   agp_clk_in,
    input  logic                   sdram_clk_in,
    input  logic                   usb_clk_in,
    input  logic                   strap_mode,
    input  logic                   pin_pdn_in,
    input  logic                   pin_cpu_stop_in,
    input  logic                   pin_pci_stop_in,
    output logic [N_CPU-1:0]       cpu_clk_o,
    output logic [N_PCI_GATED-1:0] pci_clk_o,
    output logic                   pci_free_o,
    output logic [N_AGP-1:0]       agp_clk_o,
    output logic [N_SDRAM-1:0]     sdram_clk_o,
    output logic                   shared_pin_oe,
    output logic                   usb_clk_o,
    output logic                   ref_clk_o,
    output logic                   osc_en_o
);

    localparam logic [N_SDRAM-1:0] ONE_HOT = 1;
    localparam logic [N_SDRAM-1:0] SH_MASK = (ONE_HOT << SH_PDN_BIT)
                                           | (ONE_HOT << SH_CPU_BIT)
                                           | (ONE_HOT << SH_PCI_BIT);

    logic       pdn_req, cpu_req, pci_req;
    logic       run;
    pwr_state_e pwr_state;

    logic cpu_en, pci_en, free_en, agp_en, sd_en, sd_sh_en, usb_en, ref_en;
    logic [N_SDRAM-1:0] sd_main;
    logic [0:0]         sd_sh;
    logic [0:0]         free_clk, usb_clk, ref_clk;

    // Shared pins count as requests only while the strap is low.
    assign pdn_req = ~strap_mode & pin_pdn_in;
    assign cpu_req = ~strap_mode & pin_cpu_stop_in;
    assign pci_req = ~strap_mode & pin_pci_stop_in;
    assign shared_pin_oe = strap_mode;

    clkstop_pwr_fsm #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .DRAIN_CYCLES(DRAIN_CYCLES)
    ) u_fsm (
        .clk     (ref_clk_in),
        .rst_n   (rst_n),
        .pdn_req (pdn_req),
        .state_o (pwr_state),
        .run_o   (run),
        .osc_en_o(osc_en_o)
    );

    clkstop_gate #(.WIDTH(N_CPU)) u_gate_cpu (
        .clk_in(cpu_clk_in), .rst_n(rst_n), .allow(run & ~cpu_req),
        .en_o(cpu_en), .clk_o(cpu_clk_o));

    clkstop_gate #(.WIDTH(N_PCI_GATED)) u_gate_pci (
        .clk_in(pci_clk_in), .rst_n(rst_n), .allow(run & ~pci_req),
        .en_o(pci_en), .clk_o(pci_clk_o));

    clkstop_gate #(.WIDTH(1)) u_gate_pci_free (
        .clk_in(pci_clk_in), .rst_n(rst_n), .allow(run),
        .en_o(free_en), .clk_o(free_clk));

    clkstop_gate #(.WIDTH(N_AGP)) u_gate_agp (
        .clk_in(agp_clk_in), .rst_n(rst_n), .allow(run),
        .en_o(agp_en), .clk_o(agp_clk_o));

    clkstop_gate #(.WIDTH(N_SDRAM)) u_gate_sd (
        .clk_in(sdram_clk_in), .rst_n(rst_n), .allow(run),
        .en_o(sd_en), .clk_o(sd_main));

    // Shared pins get their own gate so a strap change is also glitch-free.
    clkstop_gate #(.WIDTH(1)) u_gate_sd_sh (
        .clk_in(sdram_clk_in), .rst_n(rst_n), .allow(run & strap_mode),
        .en_o(sd_sh_en), .clk_o(sd_sh));

    clkstop_gate #(.WIDTH(1)) u_gate_usb (
        .clk_in(usb_clk_in), .rst_n(rst_n), .allow(run),
        .en_o(usb_en), .clk_o(usb_clk));

    clkstop_gate #(.WIDTH(1)) u_gate_ref (
        .clk_in(ref_clk_in), .rst_n(rst_n), .allow(run),
        .en_o(ref_en), .clk_o(ref_clk));

    assign pci_free_o = free_clk[0];
    assign usb_clk_o  = usb_clk[0];
    assign ref_clk_o  = ref_clk[0];

    for (genvar i = 0; i < N_SDRAM; i++) begin : g_sd_pin
        if (SH_MASK[i]) begin : g_shared
            assign sdram_clk_o[i] = sd_sh[0];
        end else begin : g_plain
            assign sdram_clk_o[i] = sd_main[i];
        end
    end

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
    import clkstop_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int N_PCI_GATED = 4,
    parameter int N_AGP       = 2,
    parameter int N_SDRAM     = 12,
    parameter int LOCK_CYCLES = 16
) (
    input logic                   rst_n,
    input logic                   ref_clk_in,
    input logic                   cpu_clk_in,
    input logic                   pci_clk_in,
    input logic                   strap_mode,
    input pwr_state_e             pwr_state,
    input logic                   cpu_en,
    input logic                   free_en,
    input logic [7:0]             all_en,
    input logic [N_CPU-1:0]       cpu_clk_o,
    input logic [N_PCI_GATED-1:0] pci_clk_o,
    input logic                   pci_free_o,
    input logic [N_AGP-1:0]       agp_clk_o,
    input logic [N_SDRAM-1:0]     sdram_clk_o,
    input logic                   usb_clk_o,
    input logic                   ref_clk_o,
    input logic                   osc_en_o
);

    logic all_low;
    int   lock_run;

    assign all_low = (cpu_clk_o == '0) && (pci_clk_o == '0) && !pci_free_o
                  && (agp_clk_o == '0) && (sdram_clk_o == '0)
                  && !usb_clk_o && !ref_clk_o;

    always_ff @(posedge ref_clk_in or negedge rst_n) begin
        if (!rst_n)
            lock_run <= 0;
        else if (pwr_state == PS_LOCK)
            lock_run <= lock_run + 1;
        else
            lock_run <= 0;
    end

    // R1: a closed processor enable yields low outputs in the high phase.
    p_cpu_gated_r1: assert property (@(negedge cpu_clk_in) disable iff (!rst_n)
        !cpu_en |-> (cpu_clk_o == '0));

    // R2: the free-running PCI output follows its source while enabled.
    p_pci_free_r2: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
        free_en |-> pci_free_o);

    p_down_quiet_r3: assert property (@(posedge ref_clk_in) disable iff (!rst_n)
        (pwr_state == PS_DOWN) |-> (!osc_en_o && all_low && all_en == '0));

    p_drain_before_off_r3: assert property (@(posedge ref_clk_in) disable iff (!rst_n)
        $fell(osc_en_o) |-> all_low);

    p_strap_ignores_r4: assert property (@(posedge ref_clk_in) disable iff (!rst_n)
        (strap_mode && $past(strap_mode) && $past(strap_mode, 2) && pwr_state == PS_RUN)
        |=> (pwr_state == PS_RUN));

    p_lock_len_r6: assert property (@(posedge ref_clk_in) disable iff (!rst_n)
        (pwr_state == PS_RUN && lock_run != 0) |-> (lock_run == LOCK_CYCLES));

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .N_CPU      (N_CPU),
    .N_PCI_GATED(N_PCI_GATED),
    .N_AGP      (N_AGP),
    .N_SDRAM    (N_SDRAM),
    .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
    .rst_n      (rst_n),
    .ref_clk_in (ref_clk_in),
    .cpu_clk_in (cpu_clk_in),
    .pci_clk_in (pci_clk_in),
    .strap_mode (strap_mode),
    .pwr_state  (pwr_state),
    .cpu_en     (cpu_en),
    .free_en    (free_en),
    .all_en     ({agp_en, sd_en, sd_sh_en, usb_en, ref_en, cpu_en, pci_en, free_en}),
    .cpu_clk_o  (cpu_clk_o),
    .pci_clk_o  (pci_clk_o),
    .pci_free_o (pci_free_o),
    .agp_clk_o  (agp_clk_o),
    .sdram_clk_o(sdram_clk_o),
    .usb_clk_o  (usb_clk_o),
    .ref_clk_o  (ref_clk_o),
    .osc_en_o   (osc_en_o)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps

module clkstop_pw_mon #(
    parameter real   MIN_NS = 1.0,
    parameter string LABEL  = "out"
) (
    input  logic sig,
    output int   rises,
    output int   viol
);
    realtime last = 0.0;
    bit      seen = 1'b0;
    int      r = 0;
    int      v = 0;

    assign rises = r;
    assign viol  = v;

    always @(sig) begin
        if (sig === 1'b0 || sig === 1'b1) begin
            if (seen && (($realtime - last) < (MIN_NS - 0.001))) begin
                v++;
                $display("FAIL R5 %s phase actual=%0.3f ns expected>=%0.3f ns",
                         LABEL, $realtime - last, MIN_NS);
            end
            if (sig === 1'b1) r++;
            seen = 1'b1;
            last = $realtime;
        end
    end
endmodule

module clkstop_ctrl_bench;

    localparam int  LOCK  = 16;
    localparam real H_REF = 10.0;
    localparam real H_CPU = 5.0;
    localparam real H_PCI = 15.0;
    localparam real H_AGP = 7.0;
    localparam real H_SD  = 6.0;
    localparam real H_USB = 11.0;

    logic rst_n = 1'b0;
    logic ref_clk = 1'b0, cpu_clk = 1'b0, pci_clk = 1'b0;
    logic agp_clk = 1'b0, sd_clk = 1'b0, usb_clk = 1'b0;
    logic mode = 1'b0, pin_pdn = 1'b0, pin_cpu = 1'b0, pin_pci = 1'b0;

    logic [3:0]  cpu_o;
    logic [3:0]  pci_o;
    logic        pcif_o;
    logic [1:0]  agp_o;
    logic [11:0] sd_o;
    logic        sh_oe, usb_o, ref_o, osc_en;

    int checks = 0;
    int errors = 0;

    always #(H_REF) ref_clk = ~ref_clk;
    always #(H_CPU) cpu_clk = ~cpu_clk;
    always #(H_PCI) pci_clk = ~pci_clk;
    always #(H_AGP) agp_clk = ~agp_clk;
    always #(H_SD)  sd_clk  = ~sd_clk;
    always #(H_USB) usb_clk = ~usb_clk;

    clkstop_ctrl #(.LOCK_CYCLES(LOCK)) u_clkstop_ctrl (
        .rst_n(rst_n), .ref_clk_in(ref_clk), .cpu_clk_in(cpu_clk),
        .pci_clk_in(pci_clk), .agp_clk_in(agp_clk), .sdram_clk_in(sd_clk),
        .usb_clk_in(usb_clk), .strap_mode(mode), .pin_pdn_in(pin_pdn),
        .pin_cpu_stop_in(pin_cpu), .pin_pci_stop_in(pin_pci),
        .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pci_free_o(pcif_o),
        .agp_clk_o(agp_o), .sdram_clk_o(sd_o), .shared_pin_oe(sh_oe),
        .usb_clk_o(usb_o), .ref_clk_o(ref_o), .osc_en_o(osc_en));

    int r_cpu0, r_cpu3, r_pci0, r_pcif, r_agp, r_sd0, r_sd6, r_usb, r_ref;
    int v_cpu0, v_cpu3, v_pci0, v_pcif, v_agp, v_sd0, v_sd6, v_usb, v_ref;

    clkstop_pw_mon #(.MIN_NS(H_CPU), .LABEL("cpu0")) m_cpu0 (.sig(cpu_o[0]), .rises(r_cpu0), .viol(v_cpu0));
    clkstop_pw_mon #(.MIN_NS(H_CPU), .LABEL("cpu3")) m_cpu3 (.sig(cpu_o[3]), .rises(r_cpu3), .viol(v_cpu3));
    clkstop_pw_mon #(.MIN_NS(H_PCI), .LABEL("pci0")) m_pci0 (.sig(pci_o[0]), .rises(r_pci0), .viol(v_pci0));
    clkstop_pw_mon #(.MIN_NS(H_PCI), .LABEL("pcif")) m_pcif (.sig(pcif_o),   .rises(r_pcif), .viol(v_pcif));
    clkstop_pw_mon #(.MIN_NS(H_AGP), .LABEL("agp0")) m_agp  (.sig(agp_o[0]), .rises(r_agp),  .viol(v_agp));
    clkstop_pw_mon #(.MIN_NS(H_SD),  .LABEL("sd0"))  m_sd0  (.sig(sd_o[0]),  .rises(r_sd0),  .viol(v_sd0));
    clkstop_pw_mon #(.MIN_NS(H_SD),  .LABEL("sd6"))  m_sd6  (.sig(sd_o[6]),  .rises(r_sd6),  .viol(v_sd6));
    clkstop_pw_mon #(.MIN_NS(H_USB), .LABEL("usb"))  m_usb  (.sig(usb_o),    .rises(r_usb),  .viol(v_usb));
    clkstop_pw_mon #(.MIN_NS(H_REF), .LABEL("ref"))  m_ref  (.sig(ref_o),    .rises(r_ref),  .viol(v_ref));

    // {mode, pdn, cpu_stop, pci_stop, exp_cpu, exp_pci, exp_free(all ungated groups), exp_osc, exp_shared}
    localparam logic [8:0] VEC [0:10] = '{
        9'b0000_11110,
        9'b0010_01110,
        9'b0001_10110,
        9'b0011_00110,
        9'b0100_00000,
        9'b0111_00000,
        9'b0110_00000,
        9'b0000_11110,
        9'b1111_11111,
        9'b1100_11111,
        9'b0000_11110
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int total_viol();
        return v_cpu0 + v_cpu3 + v_pci0 + v_pcif + v_agp + v_sd0 + v_sd6 + v_usb + v_ref;
    endfunction

    function automatic int total_rises();
        return r_cpu0 + r_cpu3 + r_pci0 + r_pcif + r_agp + r_sd0 + r_sd6 + r_usb + r_ref;
    endfunction

    initial begin
        #(2_000_000);
        errors++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s_cpu0, s_cpu3, s_pci0, s_pcif, s_agp, s_sd0, s_sd6, s_usb, s_ref;
        int a_cpu, a_pci, a_free, a_sh;

        // R8: reset holds every output low and keeps the oscillator on.
        repeat (20) @(negedge ref_clk);
        chk(total_rises() == 0, "R8", "output rises during reset", total_rises(), 0);
        chk(osc_en == 1'b1, "R8", "osc_en during reset", osc_en, 1);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R7.
        for (int i = 0; i < 11; i++) begin
            @(negedge ref_clk);
            {mode, pin_pdn, pin_cpu, pin_pci} = VEC[i][8:5];
            repeat (50) @(negedge ref_clk);
            s_cpu0 = r_cpu0; s_cpu3 = r_cpu3; s_pci0 = r_pci0; s_pcif = r_pcif;
            s_agp = r_agp; s_sd0 = r_sd0; s_sd6 = r_sd6; s_usb = r_usb; s_ref = r_ref;
            repeat (15) @(negedge ref_clk);
            a_cpu  = ((r_cpu0 > s_cpu0) && (r_cpu3 > s_cpu3)) ? 1 :
                     ((r_cpu0 == s_cpu0) && (r_cpu3 == s_cpu3) && cpu_o == 4'b0) ? 0 : 2;
            a_pci  = (r_pci0 > s_pci0) ? 1 : (pci_o == 4'b0) ? 0 : 2;
            a_free = ((r_pcif > s_pcif) && (r_agp > s_agp) && (r_sd0 > s_sd0)
                      && (r_usb > s_usb) && (r_ref > s_ref)) ? 1 :
                     ((r_pcif == s_pcif) && (r_agp == s_agp) && (r_sd0 == s_sd0)
                      && (r_usb == s_usb) && (r_ref == s_ref)) ? 0 : 2;
            a_sh   = (r_sd6 > s_sd6) ? 1 : (sd_o[7:5] == 3'b0) ? 0 : 2;
            chk(a_cpu == int'(VEC[i][4]), "R1 R7", $sformatf("vec%0d cpu activity", i), a_cpu, VEC[i][4]);
            chk(a_pci == int'(VEC[i][3]), "R2 R7", $sformatf("vec%0d gated pci activity", i), a_pci, VEC[i][3]);
            chk(a_free == int'(VEC[i][2]), "R2 R3", $sformatf("vec%0d free/agp/sd/usb/ref activity", i), a_free, VEC[i][2]);
            chk(osc_en == VEC[i][1], "R3", $sformatf("vec%0d osc_en", i), osc_en, VEC[i][1]);
            chk(a_sh == int'(VEC[i][0]), "R4", $sformatf("vec%0d shared sdram activity", i), a_sh, VEC[i][0]);
            chk(sh_oe == VEC[i][8], "R4", $sformatf("vec%0d shared_pin_oe", i), sh_oe, VEC[i][8]);
            chk(pci_o == 4'b0 || VEC[i][3], "R2", $sformatf("vec%0d pci level", i), pci_o, 0);
            chk(total_viol() == 0, "R5", $sformatf("vec%0d short phases", i), total_viol(), 0);
        end

        // R6: lock wait after power-down release.
        @(negedge ref_clk);
        mode = 1'b0; pin_pdn = 1'b1; pin_cpu = 1'b0; pin_pci = 1'b0;
        repeat (60) @(negedge ref_clk);
        pin_pdn = 1'b0;
        s_ref = r_ref; s_cpu0 = r_cpu0;
        repeat (LOCK) @(negedge ref_clk);
        chk(r_ref == s_ref && r_cpu0 == s_cpu0, "R6", "rises inside lock window",
            (r_ref - s_ref) + (r_cpu0 - s_cpu0), 0);
        repeat (30) @(negedge ref_clk);
        chk(r_ref > s_ref, "R6", "ref resumes after lock", r_ref - s_ref, 1);

        // R5: random request toggling at arbitrary offsets.
        for (int k = 0; k < 300; k++) begin
            @(negedge ref_clk);
            #($urandom_range(1, 97) * 0.37);
            pin_cpu = $urandom_range(0, 1);
            pin_pci = $urandom_range(0, 1);
            pin_pdn = ($urandom_range(0, 9) == 0);
        end
        @(negedge ref_clk);
        pin_cpu = 1'b0; pin_pci = 1'b0; pin_pdn = 1'b0;
        repeat (60) @(negedge ref_clk);
        s_cpu0 = r_cpu0; s_pci0 = r_pci0;
        repeat (10) @(negedge ref_clk);
        chk(r_cpu0 > s_cpu0 && r_pci0 > s_pci0, "R5", "recovery after random toggling",
            (r_cpu0 > s_cpu0) && (r_pci0 > s_pci0), 1);
        chk(total_viol() == 0, "R5", "short phases over whole run", total_viol(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule